// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor and a slower main memory. It holds sixteen lines. Each line caches one 256-byte block and keeps a valid flag, a modified flag and a 20-bit tag. The processor issues aligned 32-bit word reads and writes with a request/ready handshake. A lookup that hits completes in the same cycle, and main memory sees no traffic.

A miss stalls the processor. If the indexed line holds modified data under another tag, the old block is first streamed out to memory as a 64-beat burst. The wanted block is then streamed in as a 64-beat burst. The line becomes valid and clean with the new tag, and the held request is served as a hit. Writes that miss allocate the line the same way, then store the word and mark the line modified. Memory beats use a per-beat valid/ready handshake.

Top module: `dm_wb_cache`

## Requirements
- R1: The address is split into a tag in bits 31:12, a line index in bits 11:8 and a byte offset in bits 7:0. Bits 7:2 select the word in the block, and bits 1:0 are ignored. Two addresses with the same index and different tags compete for one line.
- R2: After reset every line is invalid, so the first access to any address misses.
- R3: A read hit raises cpu_ready_o in the cycle of the request and returns the addressed word on cpu_rdata_o. No memory beat is issued.
- R4: A write hit stores cpu_wdata_i into the addressed word and marks the line modified, with no memory beat. A later read of that word returns the new value.
- R5: A miss on an invalid or clean line issues only a refill. The refill is 64 read beats (mem_wr_o=0) that start at the block base (offset 0) and step by 4 bytes per beat.
- R6: After the last refill beat, the line is valid, clean and tagged from the request address. The held request completes as a hit in the following cycle.
- R7: A write miss fetches the block first, then writes the CPU word into it and marks the line modified.
- R8: A miss on a valid modified line first issues 64 write beats (mem_wr_o=1) to the address formed from the stored tag and the index, carrying the whole block. Only after that does the refill start.
- R9: A beat transfers only in a cycle where both mem_valid_o and mem_ready_i are high. While mem_ready_i is low, the address and direction are held.
- R10: cpu_ready_o is high only while cpu_req_i is high, and it stays low for the whole miss sequence.
- R11: A refill clears the modified flag. Evicting a refilled line that has not been written since causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request, held until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address, held with the request |
| cpu_wdata_i | input | 32 | Write word |
| cpu_ready_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | 32 | Read word, valid with cpu_ready_o |
| mem_valid_o | output | 1 | Memory beat offered |
| mem_wr_o | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr_o | output | 32 | Word address of the beat |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ready_i | input | 1 | Memory accepts or supplies the beat |
| mem_rdata_i | input | 32 | Refill data, valid with mem_ready_i |

## Verification
A wrong valid or tag bit appears at the ports in the very next access to that line. A false hit returns data with no burst. A false miss produces a 64-beat refill where none belonged. A lost or stale modified flag stays hidden until the line is evicted. Only then does the missing or extra write burst show, or a written-back block whose words differ from those the processor stored. A wrong beat counter breaks the 4-byte address step inside a burst, or the read-after-write-back order.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             mark_dirty_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= fill_tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int BEAT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              hit_i,
  input  logic              line_valid_i,
  input  logic              line_dirty_i,
  input  logic              mem_ready_i,
  output dmc_state_e        state_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              mem_valid_o,
  output logic              mem_wr_o,
  output logic              fill_line_o
);
  dmc_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              last_beat;

  assign last_beat = (beat_q == {BEAT_W{1'b1}});

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (req_i && !hit_i)
          state_d = (line_valid_i && line_dirty_i) ? ST_EVICT : ST_REFILL;
      end
      ST_EVICT: if (mem_ready_i) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_REFILL;
      end
      ST_REFILL: if (mem_ready_i) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign state_o     = state_q;
  assign beat_o      = beat_q;
  assign mem_valid_o = (state_q != ST_IDLE);
  assign mem_wr_o    = (state_q == ST_EVICT);
  assign fill_line_o = (state_q == ST_REFILL) && mem_ready_i && last_beat;
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINES       = 16,
  parameter int BLOCK_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_valid_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFS_W  = $clog2(BLOCK_BYTES);
  localparam int BSEL_W = $clog2(DATA_W / 8);
  localparam int BEAT_W = OFS_W - BSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int DEPTH  = LINES * (1 << BEAT_W);
  localparam int DA_W   = IDX_W + BEAT_W;

  logic [TAG_W-1:0]  req_tag, line_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [BEAT_W-1:0] req_word, beat;
  logic              line_valid, line_dirty, hit;
  logic              fill_line, store_hit, data_we;
  logic [DA_W-1:0]   data_raddr, data_waddr;
  logic [DATA_W-1:0] data_wdata, data_rdata;
  dmc_state_e        state;

  assign req_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign req_idx  = cpu_addr_i[OFS_W +: IDX_W];
  assign req_word = cpu_addr_i[BSEL_W +: BEAT_W];

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_i        (req_idx),
    .fill_i       (fill_line),
    .fill_tag_i   (req_tag),
    .mark_dirty_i (store_hit),
    .valid_o      (line_valid),
    .dirty_o      (line_dirty),
    .tag_o        (line_tag)
  );

  assign hit = line_valid && (line_tag == req_tag);

  dmc_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .hit_i        (hit),
    .line_valid_i (line_valid),
    .line_dirty_i (line_dirty),
    .mem_ready_i  (mem_ready_i),
    .state_o      (state),
    .beat_o       (beat),
    .mem_valid_o  (mem_valid_o),
    .mem_wr_o     (mem_wr_o),
    .fill_line_o  (fill_line)
  );

  assign cpu_ready_o = (state == ST_IDLE) && cpu_req_i && hit;
  assign store_hit   = cpu_ready_o && cpu_we_i;

  // Refill beats and CPU stores share the single write port; they never coincide.
  assign data_we    = ((state == ST_REFILL) && mem_ready_i) || store_hit;
  assign data_waddr = {req_idx, (state == ST_REFILL) ? beat : req_word};
  assign data_wdata = (state == ST_REFILL) ? mem_rdata_i : cpu_wdata_i;
  assign data_raddr = {req_idx, (state == ST_IDLE) ? req_word : beat};

  dmc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk_i   (clk_i),
    .we_i    (data_we),
    .waddr_i (data_waddr),
    .wdata_i (data_wdata),
    .raddr_i (data_raddr),
    .rdata_o (data_rdata)
  );

  assign cpu_rdata_o = data_rdata;
  assign mem_wdata_o = data_rdata;
  assign mem_addr_o  = {(state == ST_EVICT) ? line_tag : req_tag, req_idx, beat, {BSEL_W{1'b0}}};
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int ADDR_W      = 32,
  parameter int LINES       = 16,
  parameter int BLOCK_BYTES = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_ready_o,
  input logic              mem_valid_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i
);
  localparam int OFS_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(LINES);

  logic last_beat;
  assign last_beat = (mem_addr_o[OFS_W-1:2] == '1);

  a_r3_hit_no_traffic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !mem_valid_o);

  a_r10_ready_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_wr_o)));

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_ready_i && !last_beat) |=>
      (mem_valid_o && $stable(mem_wr_o) && mem_addr_o == $past(mem_addr_o) + 4));

  a_r5_burst_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_valid_o) |-> (mem_addr_o[OFS_W-1:0] == '0));

  a_r1_index_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_addr_o[OFS_W +: IDX_W] == cpu_addr_i[OFS_W +: IDX_W]));

  a_r8_refill_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_wr_o && mem_ready_i && last_beat) |=>
      (mem_valid_o && !mem_wr_o && mem_addr_o[OFS_W-1:0] == '0));

  a_r6_done_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_wr_o && mem_ready_i && last_beat) |=>
      (!mem_valid_o && (cpu_ready_o || !cpu_req_i)));
endmodule

bind dm_wb_cache dm_wb_cache_chk #(
  .ADDR_W(ADDR_W), .LINES(LINES), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (.*);

// File: tb/dm_wb_cache_tb_top.sv
`timescale 1ns/1ps
module dm_wb_cache_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic        cpu_ready_o;
  logic [31:0] cpu_rdata_o;
  logic        mem_valid_o, mem_wr_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  dm_wb_cache dut_i (.*);

  int n_cmp = 0, n_mis = 0;
  int wr_beats = 0, rd_beats = 0, seq_err = 0;
  logic [31:0] last_wr_base = '0, last_rd_base = '0, exp_next = '0;
  logic [7:0]  lfsr = 8'hA7;
  logic [31:0] mem_m [logic [31:0]];

  function automatic logic [31:0] init_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : init_word(a);
  endfunction

  // Memory model: decides ready, supplies data and logs the beat taken at the next edge.
  always @(negedge clk_i) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready_i = lfsr[0] | lfsr[1];
    mem_rdata_i = mem_rd(mem_addr_o);
    if (rst_ni && mem_valid_o && mem_ready_i) begin
      if (mem_addr_o[7:2] == 6'd0) begin
        if (mem_wr_o) last_wr_base = mem_addr_o; else last_rd_base = mem_addr_o;
      end else if (mem_addr_o != exp_next) seq_err++;
      exp_next = mem_addr_o + 32'd4;
      if (mem_wr_o) begin
        mem_m[mem_addr_o] = mem_wdata_o;
        wr_beats++;
      end else rd_beats++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
    cyc = 0;
    forever begin
      #1;
      if (cpu_ready_o) break;
      if (cyc > 2000) begin
        check("R10 hung access", 32'd0, 32'd1);
        break;
      end
      @(negedge clk_i);
      cyc++;
    end
    rd = cpu_rdata_o;
    @(posedge clk_i);
    #1 cpu_req_i = 1'b0;
  endtask

  logic [31:0] rd;
  int cyc, w0, r0;

  task automatic snap();
    w0 = wr_beats; r0 = rd_beats;
  endtask

  task automatic t_reset();
    #1;
    check("R10 ready idle", {31'd0, cpu_ready_o}, 32'd0);
    check("R2 no traffic at reset", {31'd0, mem_valid_o}, 32'd0);
  endtask

  task automatic t_cold_read();
    snap();
    cpu_op(1'b0, 32'h0007260C, '0, rd, cyc);
    check("R2 cold miss read data", rd, init_word(32'h0007260C));
    check("R5 refill beats", rd_beats - r0, 64);
    check("R5 no write-back on invalid line", wr_beats - w0, 0);
    check("R5 refill base", last_rd_base, 32'h00072600);
    check("R10 stalled during miss", {31'd0, cyc >= 64}, 32'd1);
  endtask

  task automatic t_read_hit();
    snap();
    cpu_op(1'b0, 32'h00072610, '0, rd, cyc);
    check("R3 hit data", rd, init_word(32'h00072610));
    check("R3 hit same cycle", cyc, 0);
    cpu_op(1'b0, 32'h00072613, '0, rd, cyc);
    check("R1 low bits ignored", rd, init_word(32'h00072610));
    check("R3 no beats on hit", (rd_beats + wr_beats) - (r0 + w0), 0);
  endtask

  task automatic t_write_hit();
    snap();
    cpu_op(1'b1, 32'h00072614, 32'hDEADBEEF, rd, cyc);
    check("R4 write hit same cycle", cyc, 0);
    check("R4 memory untouched", mem_rd(32'h00072614), init_word(32'h00072614));
    cpu_op(1'b0, 32'h00072614, '0, rd, cyc);
    check("R4 read after write", rd, 32'hDEADBEEF);
    check("R4 no beats", (rd_beats + wr_beats) - (r0 + w0), 0);
  endtask

  task automatic t_write_miss();
    snap();
    cpu_op(1'b1, 32'h0003A344, 32'hCAFEF00D, rd, cyc);
    check("R7 allocate refill", rd_beats - r0, 64);
    check("R7 refill base", last_rd_base, 32'h0003A300);
    check("R7 no write-back", wr_beats - w0, 0);
    cpu_op(1'b0, 32'h0003A344, '0, rd, cyc);
    check("R7 stored word", rd, 32'hCAFEF00D);
    check("R7 hit after allocate", cyc, 0);
  endtask

  task automatic t_dirty_evict();
    int bad = 0;
    snap();
    cpu_op(1'b0, 32'h002D1398, '0, rd, cyc);
    check("R8 write-back beats", wr_beats - w0, 64);
    check("R8 write-back base", last_wr_base, 32'h0003A300);
    check("R8 refill after write-back", rd_beats - r0, 64);
    check("R8 refill base", last_rd_base, 32'h002D1300);
    check("R8 new data", rd, init_word(32'h002D1398));
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a = 32'h0003A300 + 32'(i * 4);
      if (mem_rd(a) !== ((i == 17) ? 32'hCAFEF00D : init_word(a))) bad++;
    end
    check("R8 written block content", bad, 0);
  endtask

  task automatic t_clean_refill();
    snap();
    cpu_op(1'b0, 32'h00AB6600, '0, rd, cyc);
    check("R8 evict written line", wr_beats - w0, 64);
    check("R8 merged word in memory", mem_rd(32'h00072614), 32'hDEADBEEF);
    snap();
    cpu_op(1'b0, 32'h00072600, '0, rd, cyc);
    check("R11 clean line not written back", wr_beats - w0, 0);
    check("R11 refill", rd_beats - r0, 64);
    cpu_op(1'b0, 32'h00072614, '0, rd, cyc);
    check("R6 refilled data", rd, 32'hDEADBEEF);
    snap();
    cpu_op(1'b0, 32'h00AB6600, '0, rd, cyc);
    check("R11 fill cleared modified", wr_beats - w0, 0);
  endtask

  task automatic t_alias();
    snap();
    cpu_op(1'b0, 32'h00000004, '0, rd, cyc);
    cpu_op(1'b0, 32'h00001004, '0, rd, cyc);
    check("R1 same index other tag misses", rd_beats - r0, 128);
    check("R1 alias data", rd, init_word(32'h00001004));
    cpu_op(1'b0, 32'h00000104, '0, rd, cyc);
    snap();
    cpu_op(1'b0, 32'h00001004, '0, rd, cyc);
    check("R1 other index left line intact", cyc, 0);
    check("R9 burst address order", seq_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_mis++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_cold_read();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_dirty_evict();
    t_clean_refill();
    t_alias();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule